// File: doc/BRIEF.md
# Parallel SAR ADC Host Controller

This block sits on the system clock and runs a 16-bit successive-approximation converter over its parallel handshake. It drives the active-low start-convert, chip-select and read strobes and the byte-select line, and it watches the converter's busy output. Each conversion ends with one result word. The word is returned as a signed two's-complement sample, together with a single-cycle valid strobe.

A conversion begins on a one-cycle trigger, or on every idle cycle while free-running is enabled. The conversion is then read in one of two ways: as one 16-bit read, or as two 8-bit reads on the low byte lanes with the upper half fetched first. Each strobe width, setup and recovery interval is a parameter counted in system clock cycles. The defaults are rounded up for a 100 MHz clock. If busy never drops, a timeout ends the conversion with an error pulse.

Top module: `adc_par_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released with no trigger: adc_convst_no, adc_cs_no and adc_rd_no are high, adc_byte_o, smp_valid_o and err_o are low.
- R2: A trigger in idle, or free_run_i high in idle, drives adc_cs_no low. It also drives adc_convst_no low for exactly CONV_LO_CYC cycles, and adc_cs_no is low whenever adc_convst_no is low.
- R3: After the start pulse the busy input is ignored for BUSY_IGN_CYC cycles. After that, no read strobe falls until busy is sampled low.
- R4: Each read strobe stays low for RD_LO_CYC cycles with chip-select low and start-convert high. The bus is captured on the last cycle of the strobe, before it rises.
- R5: With word mode latched (byte_mode_i = 0 at start), one read is made and smp_o equals the full 16-bit bus value.
- R6: With byte mode latched (byte_mode_i = 1 at start), two reads are made, both taking bits 7:0 of the bus. The first read has adc_byte_o = 0 and supplies bits 15:8 of the result; the second has adc_byte_o = 1 and supplies bits 7:0. Bus bits 15:8 are ignored. Between the reads the strobe is high for at least RD_HI_CYC cycles, and byte-select transitions are at least BYTE_GAP_CYC cycles apart.
- R7: After the last read strobe rises, start-convert stays high for at least RD_TO_CONV_CYC cycles. Chip-select stays high for at least CS_HI_CYC cycles between conversions.
- R8: smp_valid_o is a one-cycle pulse that comes after the read strobe has risen. smp_o is signed two's complement (16'h8000 is -32768) and holds until the next sample.
- R9: If busy is still high after TIMEOUT_CYC cycles of waiting, err_o pulses for one cycle, no sample is delivered, and the controller releases all strobes and returns to idle.
- R10: A trigger while a conversion is in progress is ignored. While free_run_i is high, a new conversion starts after each one completes.
- R11: byte_mode_i is sampled only when a conversion starts. Changing it mid-conversion has no effect on that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | One-cycle conversion request |
| free_run_i | input | 1 | Restart conversions continuously |
| byte_mode_i | input | 1 | 1: two 8-bit reads, 0: one 16-bit read |
| adc_busy_i | input | 1 | Converter busy flag |
| adc_data_i | input | 16 | Converter parallel data bus |
| adc_convst_no | output | 1 | Start-convert strobe, active low |
| adc_cs_no | output | 1 | Chip-select, active low |
| adc_rd_no | output | 1 | Read strobe, active low |
| adc_byte_o | output | 1 | Half select for byte reads (0 upper, 1 lower) |
| smp_o | output | 16 | Signed sample |
| smp_valid_o | output | 1 | Sample valid pulse |
| err_o | output | 1 | Busy timeout pulse |

## Verification
The assertions check the following on every cycle:
- the strobe relations: start-convert only under chip-select, and reads exclusive with start-convert;
- the start and read pulse widths;
- no read strobe while busy is high;
- the single-cycle shape of the valid and error pulses.

Only the bench scenarios can show the rest:
- that the word or byte halves are assembled correctly for a sweep of edge and walking-bit codes, including the sign boundary;
- the recovery gaps between reads and before the next start;
- the timeout latency and the return to idle;
- that triggers mid-conversion are dropped, and that a mode change after the start is ignored.

// File: rtl/adc_par_pkg.sv
package adc_par_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CONV, ST_WAIT, ST_RD1, ST_GAP, ST_RD2, ST_REST
  } st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_par_tmr.sv
module adc_par_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/adc_par_seq.sv
module adc_par_seq
  import adc_par_pkg::*;
#(
  parameter int CONV_LO_CYC    = 2,
  parameter int CONV_HI_CYC    = 2,
  parameter int BUSY_IGN_CYC   = 3,
  parameter int RD_LO_CYC      = 5,
  parameter int RD_HI_CYC      = 2,
  parameter int CS_HI_CYC      = 2,
  parameter int BYTE_GAP_CYC   = 5,
  parameter int RD_TO_CONV_CYC = 5,
  parameter int TIMEOUT_CYC    = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic free_run_i,
  input  logic byte_mode_i,
  input  logic busy_i,
  output logic convst_no,
  output logic cs_no,
  output logic rd_no,
  output logic byte_o,
  output logic cap_o,
  output logic cap_word_o,
  output logic cap_lo_o,
  output logic err_o
);
  localparam int GAP_CYC  = max2(RD_HI_CYC, BYTE_GAP_CYC);
  localparam int REST_CYC = max2(RD_TO_CONV_CYC, max2(CS_HI_CYC, CONV_HI_CYC));
  localparam int MAX_CYC  = max2(max2(GAP_CYC, REST_CYC),
                                 max2(max2(CONV_LO_CYC, BUSY_IGN_CYC), max2(RD_LO_CYC, TIMEOUT_CYC)));
  localparam int CW = $clog2(MAX_CYC + 1);

  st_e st_q, st_d;
  logic mode_q, err_q, err_d;
  logic t_load, t_done, to_load, to_done;
  logic [CW-1:0] t_val;
  logic start;

  assign start = trig_i | free_run_i;

  adc_par_tmr #(.W(CW)) u_phase (
    .clk_i, .rst_ni, .load_i(t_load), .val_i(t_val), .done_o(t_done)
  );

  adc_par_tmr #(.W(CW)) u_tout (
    .clk_i, .rst_ni, .load_i(to_load), .val_i(CW'(TIMEOUT_CYC - 1)), .done_o(to_done)
  );

  always_comb begin
    st_d    = st_q;
    t_load  = 1'b0;
    t_val   = '0;
    to_load = 1'b0;
    cap_o   = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_CONV; t_load = 1'b1; t_val = CW'(CONV_LO_CYC - 1);
      end
      ST_CONV: if (t_done) begin
        st_d = ST_WAIT; t_load = 1'b1; t_val = CW'(BUSY_IGN_CYC - 1); to_load = 1'b1;
      end
      ST_WAIT: if (t_done) begin
        if (!busy_i) begin
          st_d = ST_RD1; t_load = 1'b1; t_val = CW'(RD_LO_CYC - 1);
        end else if (to_done) begin
          st_d = ST_REST; t_load = 1'b1; t_val = CW'(REST_CYC - 1); err_d = 1'b1;
        end
      end
      ST_RD1: if (t_done) begin
        cap_o  = 1'b1;
        t_load = 1'b1;
        if (mode_q) begin st_d = ST_GAP;  t_val = CW'(GAP_CYC - 1);  end
        else        begin st_d = ST_REST; t_val = CW'(REST_CYC - 1); end
      end
      ST_GAP: if (t_done) begin
        st_d = ST_RD2; t_load = 1'b1; t_val = CW'(RD_LO_CYC - 1);
      end
      ST_RD2: if (t_done) begin
        cap_o = 1'b1; st_d = ST_REST; t_load = 1'b1; t_val = CW'(REST_CYC - 1);
      end
      ST_REST: if (t_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      if (st_q == ST_IDLE && start) mode_q <= byte_mode_i;
    end
  end

  // strobes are decoded from the state register only
  assign convst_no  = (st_q != ST_CONV);
  assign cs_no      = (st_q == ST_IDLE) || (st_q == ST_REST);
  assign rd_no      = !((st_q == ST_RD1) || (st_q == ST_RD2));
  assign byte_o     = (st_q == ST_GAP) || (st_q == ST_RD2);
  assign cap_word_o = !mode_q;
  assign cap_lo_o   = (st_q == ST_RD2);
  assign err_o      = err_q;
endmodule

// File: rtl/adc_par_cap.sv
module adc_par_cap #(
  parameter int DATA_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic                     word_i,
  input  logic                     lo_i,
  input  logic [DATA_W-1:0]        data_i,
  output logic signed [DATA_W-1:0] smp_o,
  output logic                     valid_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [HALF_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      smp_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (cap_i) begin
        if (word_i) begin
          smp_o   <= data_i;
          valid_o <= 1'b1;
        end else if (!lo_i) begin
          hi_q <= data_i[HALF_W-1:0];
        end else begin
          smp_o   <= {hi_q, data_i[HALF_W-1:0]};
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adc_par_ctrl.sv
module adc_par_ctrl #(
  parameter int DATA_W         = 16,
  parameter int CONV_LO_CYC    = 2,
  parameter int CONV_HI_CYC    = 2,
  parameter int BUSY_IGN_CYC   = 3,
  parameter int RD_LO_CYC      = 5,
  parameter int RD_HI_CYC      = 2,
  parameter int CS_HI_CYC      = 2,
  parameter int BYTE_GAP_CYC   = 5,
  parameter int RD_TO_CONV_CYC = 5,
  parameter int TIMEOUT_CYC    = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     trig_i,
  input  logic                     free_run_i,
  input  logic                     byte_mode_i,
  input  logic                     adc_busy_i,
  input  logic [DATA_W-1:0]        adc_data_i,
  output logic                     adc_convst_no,
  output logic                     adc_cs_no,
  output logic                     adc_rd_no,
  output logic                     adc_byte_o,
  output logic signed [DATA_W-1:0] smp_o,
  output logic                     smp_valid_o,
  output logic                     err_o
);
  logic cap, cap_word, cap_lo;

  adc_par_seq #(
    .CONV_LO_CYC(CONV_LO_CYC), .CONV_HI_CYC(CONV_HI_CYC), .BUSY_IGN_CYC(BUSY_IGN_CYC),
    .RD_LO_CYC(RD_LO_CYC), .RD_HI_CYC(RD_HI_CYC), .CS_HI_CYC(CS_HI_CYC),
    .BYTE_GAP_CYC(BYTE_GAP_CYC), .RD_TO_CONV_CYC(RD_TO_CONV_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .trig_i, .free_run_i, .byte_mode_i,
    .busy_i(adc_busy_i),
    .convst_no(adc_convst_no), .cs_no(adc_cs_no), .rd_no(adc_rd_no), .byte_o(adc_byte_o),
    .cap_o(cap), .cap_word_o(cap_word), .cap_lo_o(cap_lo), .err_o
  );

  adc_par_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i, .rst_ni, .cap_i(cap), .word_i(cap_word), .lo_i(cap_lo),
    .data_i(adc_data_i), .smp_o, .valid_o(smp_valid_o)
  );
endmodule

// File: rtl/adc_par_chk.sv
module adc_par_chk #(
  parameter int RD_LO_CYC   = 5,
  parameter int CONV_LO_CYC = 2
) (
  input logic clk_i,
  input logic rst_ni,
  input logic adc_convst_no,
  input logic adc_cs_no,
  input logic adc_rd_no,
  input logic adc_byte_o,
  input logic adc_busy_i,
  input logic smp_valid_o,
  input logic err_o
);
  logic [7:0] rd_run, cv_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_run <= '0;
      cv_run <= '0;
    end else begin
      rd_run <= adc_rd_no     ? 8'd0 : ((rd_run == 8'hFF) ? rd_run : rd_run + 8'd1);
      cv_run <= adc_convst_no ? 8'd0 : ((cv_run == 8'hFF) ? cv_run : cv_run + 8'd1);
    end
  end

  AST_CONVST_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_convst_no |-> !adc_cs_no); // R2
  AST_CONVST_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_convst_no && cv_run != 8'd0) |-> (int'(cv_run) >= CONV_LO_CYC)); // R2
  AST_RD_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(adc_rd_no) |-> !adc_busy_i); // R3
  AST_RD_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adc_rd_no && rd_run != 8'd0) |-> (int'(rd_run) >= RD_LO_CYC)); // R4
  AST_RD_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> (adc_convst_no && !adc_cs_no)); // R4
  AST_BYTE_UNDER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_byte_o |-> !adc_cs_no); // R6
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o); // R8
  AST_VALID_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> adc_rd_no); // R8
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R9
  AST_ERR_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !smp_valid_o); // R9
endmodule

bind adc_par_ctrl adc_par_chk #(.RD_LO_CYC(RD_LO_CYC), .CONV_LO_CYC(CONV_LO_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adc_convst_no(adc_convst_no), .adc_cs_no(adc_cs_no),
  .adc_rd_no(adc_rd_no), .adc_byte_o(adc_byte_o), .adc_busy_i(adc_busy_i),
  .smp_valid_o(smp_valid_o), .err_o(err_o)
);

// File: tb/tb_adc_par_ctrl.sv
`timescale 1ns/1ps
module tb_adc_par_ctrl;
  localparam int CONV_LO = 2, RD_LO = 5, RD_HI = 2, CS_HI = 2, BYTE_GAP = 5, RD2CONV = 5, TOUT = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trig = 1'b0, free_run = 1'b0, byte_mode = 1'b0, busy = 1'b0;
  logic [15:0] data;
  logic convst_n, cs_n, rd_n, byte_sel, valid, err;
  logic signed [15:0] smp;

  logic [15:0] cur = 16'h0;
  logic model_byte = 1'b0, hang = 1'b0;
  int conv_len = 5;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_par_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .free_run_i(free_run), .byte_mode_i(byte_mode),
    .adc_busy_i(busy), .adc_data_i(data), .adc_convst_no(convst_n), .adc_cs_no(cs_n),
    .adc_rd_no(rd_n), .adc_byte_o(byte_sel), .smp_o(smp), .smp_valid_o(valid), .err_o(err)
  );

  // converter model: bus is garbage whenever not read
  assign data = (!cs_n && !rd_n) ?
                (model_byte ? (byte_sel ? {8'hA5, cur[7:0]} : {8'h5A, cur[15:8]}) : cur) : 16'hDEAD;

  initial forever begin
    @(negedge convst_n);
    repeat (2) @(posedge clk);
    #1 busy = 1'b1;
    repeat (conv_len) @(posedge clk);
    wait (!hang);
    #1 busy = 1'b0;
  end

  // interval monitors
  int rd_lo_run = 0, cv_lo_run = 0, rd_hi_run = 0, since_rd = 1000, cs_hi_run = 0, since_byte = 1000;
  int min_rd_lo = 1000, min_cv_lo = 1000, min_rd_hi = 1000, min_gap = 1000, min_cs_hi = 1000, min_byte = 1000;
  int bad_busy = 0, conv_falls = 0, valid_cnt = 0, err_cnt = 0;
  logic p_rd = 1'b1, p_cv = 1'b1, p_cs = 1'b1, p_byte = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (!rd_n) rd_lo_run++; else begin if (!p_rd && rd_lo_run < min_rd_lo) min_rd_lo = rd_lo_run; rd_lo_run = 0; end
    if (!convst_n) cv_lo_run++; else begin if (!p_cv && cv_lo_run < min_cv_lo) min_cv_lo = cv_lo_run; cv_lo_run = 0; end
    if (!cs_n && rd_n) rd_hi_run++;
    if (!rd_n && p_rd && rd_hi_run < min_rd_hi) min_rd_hi = rd_hi_run;
    if (cs_n || !rd_n) rd_hi_run = 0;
    if (!rd_n && p_rd && busy) bad_busy++;
    if (!convst_n && p_cv) begin conv_falls++; if (since_rd < min_gap) min_gap = since_rd; end
    if (rd_n) since_rd++; else since_rd = 0;
    if (cs_n) cs_hi_run++; else begin if (p_cs && cs_hi_run < min_cs_hi) min_cs_hi = cs_hi_run; cs_hi_run = 0; end
    if (byte_sel != p_byte) begin if (since_byte < min_byte) min_byte = since_byte; since_byte = 0; end
    since_byte++;
    if (valid) valid_cnt++;
    if (err) err_cnt++;
    p_rd = rd_n; p_cv = convst_n; p_cs = cs_n; p_byte = byte_sel;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_conv(input logic [15:0] v, input logic bm, input int len, input bit flip);
    bit got = 1'b0;
    cur = v; model_byte = bm; byte_mode = bm; conv_len = len;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    if (flip) byte_mode = ~bm;
    for (int k = 0; k < 400 && !got; k++) begin
      @(negedge clk);
      if (valid) got = 1'b1;
    end
    chk(got, "R8 valid seen", int'(got), 1);
    chk(smp == $signed(v), bm ? (flip ? "R11 byte latched" : "R6 byte sample") : (flip ? "R11 word latched" : "R5 word sample"),
        int'(smp), int'(v));
    @(negedge clk);
    chk(!valid, "R8 single pulse", int'(valid), 0);
    chk(smp == $signed(v), "R8 sample held", int'(smp), int'(v));
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int base_v, base_c, cyc;
    repeat (3) @(negedge clk);
    chk(convst_n && cs_n && rd_n && !byte_sel && !valid && !err, "R1 in reset",
        {convst_n, cs_n, rd_n, byte_sel, valid, err}, 6'b111000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(convst_n && cs_n && rd_n && !byte_sel && !valid && !err, "R1 after reset",
        {convst_n, cs_n, rd_n, byte_sel, valid, err}, 6'b111000);

    // sweep: edge codes, repeated-nibble codes, walking ones, both modes, two conversion lengths
    for (int m = 0; m < 2; m++)
      for (int l = 0; l < 2; l++) begin
        for (int i = 0; i < 16; i++) run_conv(16'(i * 16'h1111), m[0], l ? 30 : 5, 1'b0);
        for (int i = 0; i < 16; i++) run_conv(16'h1 << i, m[0], l ? 30 : 5, 1'b0);
        run_conv(16'h8000, m[0], 12, 1'b0);
        chk(smp == -16'sd32768, "R8 negative full scale", int'(smp), 32'hFFFF8000);
        run_conv(16'h7FFF, m[0], 12, 1'b0);
      end

    // mode change after start is ignored
    run_conv(16'hC35A, 1'b1, 10, 1'b1);
    run_conv(16'h3CA5, 1'b0, 10, 1'b1);
    byte_mode = 1'b0;

    // trigger during a conversion is dropped
    base_v = valid_cnt; base_c = conv_falls;
    cur = 16'h1234; model_byte = 1'b0; conv_len = 30;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (10) @(negedge clk);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    repeat (80) @(negedge clk);
    chk(conv_falls - base_c == 1, "R10 trigger ignored", conv_falls - base_c, 1);
    chk(valid_cnt - base_v == 1, "R10 one sample", valid_cnt - base_v, 1);

    // free-running
    base_v = valid_cnt; base_c = conv_falls; conv_len = 6;
    free_run = 1'b1;
    for (int k = 0; k < 1000 && valid_cnt - base_v < 3; k++) @(negedge clk);
    free_run = 1'b0;
    repeat (100) @(negedge clk);
    chk(valid_cnt - base_v >= 3, "R10 free-run samples", valid_cnt - base_v, 3);
    chk(conv_falls - base_c == valid_cnt - base_v, "R10 free-run starts", conv_falls - base_c, valid_cnt - base_v);

    // busy timeout
    base_v = valid_cnt; hang = 1'b1; conv_len = 5; cyc = 0;
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    while (!err && cyc < 300) begin @(negedge clk); cyc++; end
    chk(cyc >= TOUT && cyc <= TOUT + 8, "R9 timeout latency", cyc, TOUT);
    @(negedge clk);
    chk(!err, "R9 error pulse", int'(err), 0);
    repeat (10) @(negedge clk);
    chk(convst_n && cs_n && rd_n, "R9 back to idle", {convst_n, cs_n, rd_n}, 3'b111);
    chk(valid_cnt == base_v, "R9 no sample", valid_cnt - base_v, 0);
    chk(err_cnt == 1, "R9 error count", err_cnt, 1);
    hang = 1'b0;
    repeat (10) @(negedge clk);
    run_conv(16'hBEEF, 1'b1, 8, 1'b0);

    chk(min_cv_lo == CONV_LO, "R2 start width", min_cv_lo, CONV_LO);
    chk(bad_busy == 0, "R3 read under busy", bad_busy, 0);
    chk(min_rd_lo >= RD_LO, "R4 read width", min_rd_lo, RD_LO);
    chk(min_rd_hi >= RD_HI, "R6 read gap", min_rd_hi, RD_HI);
    chk(min_byte >= BYTE_GAP, "R6 byte spacing", min_byte, BYTE_GAP);
    chk(min_gap >= RD2CONV, "R7 read to start", min_gap, RD2CONV);
    chk(min_cs_hi >= CS_HI, "R7 cs high", min_cs_hi, CS_HI);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule